// File: doc/BRIEF.md
# PSRAM Asynchronous Bus Controller

This block sits between a clocked request port and a 256K x 16 pseudo-static RAM that has an asynchronous pin interface. A requester offers single-word reads and writes through a valid/ready handshake. Each request carries an 18-bit word address, 16 bits of write data and a two-bit byte mask. The controller turns each request into the memory's pin sequence: chip selects, output enable, write enable, active-low byte enables, the address, and a split data bus (drive value, drive enable, sampled input). Read data returns with a one-cycle valid pulse, and responses come back in request order.

Every memory timing figure is a parameter in nanoseconds, chosen by a speed-grade parameter of 55, 60 or 70 ns. Each figure becomes a cycle count equal to the ceiling of the nanoseconds over the clock period, and never less than one. Each access first presents the address for one cycle with the chip deselected, so reads are chip-select controlled.

The memory needs a deselect of at least one read cycle time in any 15 µs window. The controller tracks the time since its last deselect of that length. When that time reaches a threshold set just under 15 µs, it stops accepting requests and holds the chip deselected for one full read cycle time.

Top module: `psramBusCtrl`

## Requirements
- R1: After reset the memory is deselected (memCe1N=1, memCe2=0), memOeN=1, memWeN=1, memDqOe=0, reqReady=1 and rspValid=0.
- R2: A read holds the address unchanged from the cycle before chip select goes active. Chip select and output enable are then held active for exactly ceil(tRC/Tclk) cycles (14 at 55 ns and 4 ns), and the data sampled at the end returns on rspData with rspValid high for one cycle.
- R3: A write holds memWeN low for exactly ceil(max(WE pulse, select-to-write-end, address-to-write-end, data setup)/Tclk) cycles (12 at 55 ns and 4 ns). Address and drive data stay stable throughout, and data is still driven in the cycle WE returns high.
- R4: After a write's chip-select activation, the next chip-select activation comes no sooner than ceil(tWC/Tclk) cycles (14 at 55 ns and 4 ns).
- R5: reqMask bit 0 enables the low byte (memBleN low, data bits 7:0) and bit 1 enables the high byte (memBheN low, bits 15:8). A write changes only the enabled bytes. A read returns zero in every byte lane whose mask bit is clear.
- R6: A request with reqMask=00 is accepted without any chip-select activation. As a read, it returns rspValid with rspData=0. As a write, it leaves memory unchanged.
- R7: memDqOe is high only during write sequences. It is low in every cycle where memOeN is low and in the cycle before.
- R8: While back-to-back requests keep the chip deselected for less than tRC between accesses, the controller inserts a deselect of at least ceil(tRC/Tclk) cycles, with reqReady low. Between two such deselects there are never more than ceil(15000 ns/Tclk) cycles.
- R9: reqReady is low in the cycle after a request with a non-zero mask is accepted, so only one access is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be taken this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Byte mask, bit 0 low byte, bit 1 high byte |
| rspValid | output | 1 | Read data valid pulse |
| rspData | output | 16 | Read data |
| memCe1N | output | 1 | Active-low chip select |
| memCe2 | output | 1 | Active-high chip select |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memBheN | output | 1 | Active-low high-byte enable |
| memBleN | output | 1 | Active-low low-byte enable |
| memAddr | output | 18 | Memory address |
| memDqOut | output | 16 | Data to drive onto the memory bus |
| memDqOe | output | 1 | Drive enable for memDqOut |
| memDqIn | input | 16 | Data sampled from the memory bus |

## Verification
The bench tests full-word, low-byte-only and high-byte-only writes and reads against a behavioural memory. These show whether each mask bit reaches the right enable pin and lane. The memory returns a filler pattern on disabled lanes, so a read that fails to zero a lane shows up. Zero-mask requests separate "accepted but skipped" from "issued to the bus" by counting chip-select activations. A long run of back-to-back reads separates a controller that enforces the periodic full deselect from one that only meets per-access timing. Pulse widths and spacings are measured cycle by cycle at the pins.

// File: rtl/psramPkg.sv
package psramPkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RSETUP,
    S_READ,
    S_WSETUP,
    S_WPULSE,
    S_WREC,
    S_GUARD
  } stateT;

  // control -> datapath strobes
  typedef struct packed {
    logic loadReq;   // latch request fields
    logic selOn;     // chip selected
    logic oeOn;      // output enable active
    logic weOn;      // write enable active
    logic drvOn;     // data drivers on
    logic capture;   // sample read data, raise response
    logic zeroResp;  // answer a zero-mask read with zero
  } strobeT;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // ceiling division, never below one cycle
  function automatic int nsToCyc(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int wePulseNs(input int grade);
    return (grade >= 70) ? 45 : 40;
  endfunction

  function automatic int selToEndNs(input int grade);
    return (grade >= 70) ? 55 : 45;
  endfunction

  localparam int DATA_SETUP_NS = 25;

endpackage

// File: rtl/psramCtrl.sv
module psramCtrl
  import psramPkg::*;
#(
  parameter int RC_CYC    = 14,
  parameter int WP_CYC    = 12,
  parameter int WREC_CYC  = 1,
  parameter int GUARD_CYC = 3500,
  parameter int LIMIT_CYC = 3750
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  input  logic [1:0] reqMask,
  output logic   reqReady,
  output strobeT strobe
);

  localparam int CNT_MAX = maxOf(RC_CYC, maxOf(WP_CYC, WREC_CYC));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int DES_W   = $clog2(RC_CYC + 1);
  localparam int TMR_W   = $clog2(GUARD_CYC + 1);

  stateT            state;
  logic [CNT_W-1:0] cnt;
  logic [DES_W-1:0] deselCnt;
  logic [TMR_W-1:0] selTimer;

  logic accept, maskNone, selected, longDesel, guardDue;

  assign maskNone  = (reqMask == 2'b00);
  assign selected  = (state == S_READ) || (state == S_WPULSE);
  assign longDesel = (deselCnt >= DES_W'(RC_CYC));
  assign guardDue  = (selTimer >= TMR_W'(GUARD_CYC));
  assign reqReady  = (state == S_IDLE) && !guardDue;
  assign accept    = reqValid && reqReady;

  // sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (guardDue) state <= S_GUARD;
          else if (accept && !maskNone) state <= reqWrite ? S_WSETUP : S_RSETUP;
        end
        S_RSETUP: begin
          state <= S_READ;
          cnt   <= CNT_W'(RC_CYC - 1);
        end
        S_READ: begin
          if (cnt == '0) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        S_WSETUP: begin
          state <= S_WPULSE;
          cnt   <= CNT_W'(WP_CYC - 1);
        end
        S_WPULSE: begin
          if (cnt == '0) begin
            state <= S_WREC;
            cnt   <= CNT_W'(WREC_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_WREC: begin
          if (cnt == '0) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        S_GUARD: begin
          if (longDesel) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // deselect run length and time since last long deselect (R8)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      deselCnt <= '0;
      selTimer <= '0;
    end else begin
      if (selected) deselCnt <= '0;
      else if (!longDesel) deselCnt <= deselCnt + 1'b1;

      if (longDesel) selTimer <= '0;
      else if (!guardDue) selTimer <= selTimer + 1'b1;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.loadReq  = accept;
    strobe.selOn    = selected;
    strobe.oeOn     = (state == S_READ);
    strobe.weOn     = (state == S_WPULSE);
    strobe.drvOn    = (state == S_WSETUP) || (state == S_WPULSE) || (state == S_WREC);
    strobe.capture  = (state == S_READ) && (cnt == '0);
    strobe.zeroResp = accept && maskNone && !reqWrite;
  end

  // independent window checker for R8: counts select activity directly
  localparam int CHK_W = $clog2(LIMIT_CYC + 2);
  logic [CHK_W-1:0] chkSince;
  logic [DES_W-1:0] chkHigh;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkSince <= '0;
      chkHigh  <= '0;
    end else begin
      if (strobe.selOn) chkHigh <= '0;
      else if (chkHigh < DES_W'(RC_CYC)) chkHigh <= chkHigh + 1'b1;
      if (chkHigh >= DES_W'(RC_CYC)) chkSince <= '0;
      else if (chkSince < CHK_W'(LIMIT_CYC + 1)) chkSince <= chkSince + 1'b1;
    end
  end

  a_r8_deselect_window: assert property (@(posedge clk) disable iff (!rstN)
    chkSince <= CHK_W'(LIMIT_CYC));

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !maskNone) |=> !reqReady);

  a_r8_guard_blocks_requests: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_GUARD) |-> (!reqReady && !strobe.selOn));

endmodule

// File: rtl/psramDatapath.sv
module psramDatapath
  import psramPkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strobe,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqMask,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData,
  output logic                memCe1N,
  output logic                memCe2,
  output logic                memOeN,
  output logic                memWeN,
  output logic [DATA_W/8-1:0] memByteN,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memDqOut,
  output logic                memDqOe,
  input  logic [DATA_W-1:0]   memDqIn
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] laneData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      maskQ <= '0;
    end else if (strobe.loadReq) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
      maskQ <= reqMask;
    end
  end

  // per-lane enables and read masking
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign memByteN[g]        = !(strobe.selOn && maskQ[g]);
    assign laneData[g*8 +: 8] = maskQ[g] ? memDqIn[g*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.capture || strobe.zeroResp;
      if (strobe.capture) rspData <= laneData;
      else if (strobe.zeroResp) rspData <= '0;
    end
  end

  assign memAddr  = addrQ;
  assign memCe1N  = !strobe.selOn;
  assign memCe2   = strobe.selOn;
  assign memOeN   = !strobe.oeOn;
  assign memWeN   = !strobe.weOn;
  assign memDqOe  = strobe.drvOn;
  assign memDqOut = strobe.drvOn ? dataQ : '0;

  a_r7_drivers_clear_of_oe: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (!memDqOe && !$past(memDqOe)));

  a_r2_addr_before_select: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCe1N) |-> $stable(memAddr));

  a_r3_we_inside_select: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCe1N && memCe2 && memDqOe && memOeN && (memByteN != '1)));

  a_r3_write_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> ($stable(memDqOut) && $stable(memAddr)));

  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (memDqOe && $stable(memDqOut)));

endmodule

// File: rtl/psramBusCtrl.sv
module psramBusCtrl
  import psramPkg::*;
#(
  parameter int CLK_NS   = 4,
  parameter int GRADE_NS = 55,
  parameter int GUARD_NS = 14000,
  parameter int LIMIT_NS = 15000,
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memBheN,
  output logic              memBleN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int RC_CYC    = nsToCyc(GRADE_NS, CLK_NS);
  localparam int WC_CYC    = nsToCyc(GRADE_NS, CLK_NS);
  localparam int WP_NS     = maxOf(maxOf(wePulseNs(GRADE_NS), selToEndNs(GRADE_NS)), DATA_SETUP_NS);
  localparam int WP_CYC    = nsToCyc(WP_NS, CLK_NS);
  localparam int WREC_CYC  = maxOf(1, WC_CYC - 1 - WP_CYC);
  localparam int GUARD_CYC = nsToCyc(GUARD_NS, CLK_NS);
  localparam int LIMIT_CYC = nsToCyc(LIMIT_NS, CLK_NS);

  strobeT    strobe;
  logic [1:0] byteN;

  psramCtrl #(
    .RC_CYC   (RC_CYC),
    .WP_CYC   (WP_CYC),
    .WREC_CYC (WREC_CYC),
    .GUARD_CYC(GUARD_CYC),
    .LIMIT_CYC(LIMIT_CYC)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqMask (reqMask),
    .reqReady(reqReady),
    .strobe  (strobe)
  );

  psramDatapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .rspValid(rspValid),
    .rspData (rspData),
    .memCe1N (memCe1N),
    .memCe2  (memCe2),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .memByteN(byteN),
    .memAddr (memAddr),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe),
    .memDqIn (memDqIn)
  );

  assign memBleN = byteN[0];
  assign memBheN = byteN[1];

endmodule

// File: tb/tb_psramBusCtrl.sv
module tb_psramBusCtrl;

  localparam int T_NS     = 4;
  localparam int RC_EXP   = (55 + T_NS - 1) / T_NS;   // 14
  localparam int WP_EXP   = (45 + T_NS - 1) / T_NS;   // 12
  localparam int WC_EXP   = (55 + T_NS - 1) / T_NS;   // 14
  localparam int LIMIT_EXP = 15000 / T_NS;            // 3750

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic reqReady, rspValid;
  logic [15:0] rspData;
  logic memCe1N, memCe2, memOeN, memWeN, memBheN, memBleN, memDqOe;
  logic [17:0] memAddr;
  logic [15:0] memDqOut;
  logic [15:0] memDqIn = 16'h5A5A;

  always #(T_NS/2) clk = ~clk;

  psramBusCtrl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspValid(rspValid), .rspData(rspData), .memCe1N(memCe1N), .memCe2(memCe2),
    .memOeN(memOeN), .memWeN(memWeN), .memBheN(memBheN), .memBleN(memBleN),
    .memAddr(memAddr), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference contents and scoreboard
  logic [15:0] refMem [int];
  logic [15:0] modelMem [int];
  logic [15:0] expQ [$];
  string       tagQ [$];

  function automatic logic [15:0] rdRef(input int a);
    return refMem.exists(a) ? refMem[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] rdModel(input int a);
    return modelMem.exists(a) ? modelMem[a] : 16'h0000;
  endfunction

  // behavioural memory and pin timing monitor
  logic        prevWeN = 1'b1, prevSel = 1'b0, prevOeN = 1'b1, prevDqOe = 1'b0;
  logic        prevBleN = 1'b1, prevBheN = 1'b1;
  logic [17:0] prevAddr = '0;
  logic [15:0] prevDq = '0;
  int cyc = 0, weRun = 0, oeRun = 0, highRun = 0, sinceLong = 0;
  int lastFall = -1000;
  bit lastFallWr = 0, limitFlagged = 0, streamOn = 0;
  int guardSeen = 0, ceFalls = 0;

  always @(negedge clk) begin
    logic sel;
    logic [15:0] cur;
    cyc++;
    if (rstN) begin
      sel = !memCe1N && memCe2;
      // write commit on WE rising
      if (!prevWeN && memWeN) begin
        cur = rdModel(int'(prevAddr));
        if (!prevBleN) cur[7:0]  = prevDq[7:0];
        if (!prevBheN) cur[15:8] = prevDq[15:8];
        modelMem[int'(prevAddr)] = cur;
        chk(weRun == WP_EXP, "R3 write pulse width", weRun, WP_EXP);
        chk(memDqOe && memDqOut == prevDq, "R3 data held at WE rise", memDqOut, prevDq);
      end
      if (!memWeN) weRun++; else weRun = 0;
      // read pulse width
      if (!prevOeN && memOeN) chk(oeRun == RC_EXP, "R2 read select width", oeRun, RC_EXP);
      if (!memOeN) oeRun++; else oeRun = 0;
      // drivers clear of OE
      if (prevOeN && !memOeN)
        chk(!memDqOe && !prevDqOe, "R7 drivers off around OE", {memDqOe, prevDqOe}, 0);
      // select activation: address setup and write spacing
      if (sel && !prevSel) begin
        ceFalls++;
        chk(memAddr == prevAddr, "R2 address set before select", memAddr, prevAddr);
        if (lastFallWr)
          chk(cyc - lastFall >= WC_EXP, "R4 write cycle spacing", cyc - lastFall, WC_EXP);
        lastFall = cyc;
        lastFallWr = !memWeN;
      end
      // long deselect window
      if (!sel) highRun++; else highRun = 0;
      if (highRun == RC_EXP && streamOn) guardSeen++;
      if (highRun >= RC_EXP) sinceLong = 0; else sinceLong++;
      if (sinceLong > LIMIT_EXP && !limitFlagged) begin
        limitFlagged = 1;
        chk(0, "R8 deselect window exceeded", sinceLong, LIMIT_EXP);
      end
      // read data returned by the memory
      if (sel && !memOeN && memWeN) begin
        cur = rdModel(int'(memAddr));
        memDqIn = {memBheN ? 8'hA5 : cur[15:8], memBleN ? 8'hA5 : cur[7:0]};
      end else memDqIn = 16'h5A5A;
      prevSel = sel;
    end
    prevWeN = memWeN; prevOeN = memOeN; prevDqOe = memDqOe;
    prevBleN = memBleN; prevBheN = memBheN; prevAddr = memAddr; prevDq = memDqOut;
  end

  // response monitor
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) chk(0, "R9 unexpected response", rspData, 0);
      else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(rspData == e, t, rspData, e);
      end
    end
  end

  // driver: waits for ready, records expectation at acceptance
  task automatic sendReq(input bit wr, input int a, input logic [15:0] d,
                         input logic [1:0] m, input string tag);
    logic [15:0] cur;
    reqValid = 1'b1; reqWrite = wr; reqAddr = 18'(a); reqWdata = d; reqMask = m;
    while (!reqReady) @(negedge clk);
    if (wr) begin
      cur = rdRef(a);
      if (m[0]) cur[7:0]  = d[7:0];
      if (m[1]) cur[15:8] = d[15:8];
      refMem[a] = cur;
    end else begin
      cur = rdRef(a);
      expQ.push_back({m[1] ? cur[15:8] : 8'h00, m[0] ? cur[7:0] : 8'h00});
      tagQ.push_back(tag);
    end
    @(negedge clk);
    reqValid = 1'b0;
    if (m != 2'b00) chk(!reqReady, "R9 not ready while busy", reqReady, 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && expQ.size() != 0; i++) @(negedge clk);
    chk(expQ.size() == 0, "R2 all responses returned", expQ.size(), 0);
  endtask

  initial begin : mainSeq
    int falls0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(memCe1N && !memCe2, "R1 deselected", {memCe1N, memCe2}, 2'b10);
    chk(memOeN && memWeN, "R1 OE/WE idle", {memOeN, memWeN}, 2'b11);
    chk(!memDqOe, "R1 drivers off", memDqOe, 0);
    chk(reqReady && !rspValid, "R1 ready, no response", {reqReady, rspValid}, 2'b10);

    // R2/R3 full-word writes and reads
    sendReq(1, 18'h00010, 16'hBEEF, 2'b11, "R3 write");
    sendReq(1, 18'h3FFFF, 16'h1234, 2'b11, "R3 write top");
    sendReq(0, 18'h00010, 0, 2'b11, "R2 read full word");
    sendReq(0, 18'h3FFFF, 0, 2'b11, "R2 read top address");
    // R5 byte lanes
    sendReq(1, 18'h00010, 16'h77CC, 2'b01, "R5 low byte write");
    sendReq(0, 18'h00010, 0, 2'b11, "R5 after low-byte write");
    sendReq(1, 18'h00010, 16'h99AA, 2'b10, "R5 high byte write");
    sendReq(0, 18'h00010, 0, 2'b11, "R5 after high-byte write");
    sendReq(0, 18'h00010, 0, 2'b01, "R5 low lane read zeroes high");
    sendReq(0, 18'h00010, 0, 2'b10, "R5 high lane read zeroes low");
    drain();

    // R6 zero-mask requests
    falls0 = ceFalls;
    sendReq(1, 18'h00010, 16'h0000, 2'b00, "R6 zero-mask write");
    sendReq(0, 18'h00010, 0, 2'b00, "R6 zero-mask read");
    repeat (4) @(negedge clk);
    chk(ceFalls == falls0, "R6 no select for zero mask", ceFalls, falls0);
    sendReq(0, 18'h00010, 0, 2'b11, "R6 memory unchanged");
    drain();

    // R8 long stream of back-to-back reads
    for (int i = 0; i < 8; i++) sendReq(1, 100 + i, 16'(16'h4000 + i * 16'h0111), 2'b11, "R3 fill");
    repeat (20) @(negedge clk);
    streamOn = 1;
    for (int i = 0; i < 300; i++) sendReq(0, 100 + (i % 8), 0, 2'b11, "R8 stream read");
    streamOn = 0;
    drain();
    chk(guardSeen >= 1, "R8 guard deselect inserted", guardSeen, 1);
    chk(!limitFlagged, "R8 window respected", limitFlagged, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule